// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Engine

This engine takes a byte-wide incoming stream and writes each packet into memory buffers. The buffers come from a chain of descriptors that software places in memory. For each descriptor, the engine reads four header words from memory through a single request/acknowledge port. It then fills that descriptor's buffer one byte at a time, and afterwards writes a status word back into the descriptor. When a packet is longer than one buffer, the remaining bytes go into the buffer of the next descriptor in the chain. The status word marks the piece that opened the packet and the piece that closed it.

A separate 32-bit sideband stream delivers application words for each packet. These words are kept in a small buffer and copied into the descriptor that receives the packet's last byte. Control is given by plain signals, since register decode lives outside this block:

- a run level;
- a current-pointer load;
- a tail-pointer load.

Idle, halted, a completion pulse and a sideband error pulse come out as plain outputs.

Descriptor layout, as byte offsets from the descriptor address:

| Offset | Content |
|---|---|
| +0 | next-descriptor pointer |
| +4 | buffer address |
| +8 | length in bytes, bits [22:0] |
| +12 | status |
| +16 to +32 | five application words |

Top module: `s2m_sg_engine`

## Requirements
- R1: A descriptor receives at most the byte count in bits [22:0] of its length word. Any further bytes of the packet go to the next descriptor. Stream bytes are written as single-byte stores, with `mem_wstrb` one-hot at lane `mem_addr[1:0]` and the byte repeated on all four lanes of `mem_wdata`.
- R2: If a fetched status word already has bit 31 set, halted is raised. No stream byte is then accepted and no memory write is issued.
- R3: The descriptor that receives a packet's first byte gets status bit 27 set in its write-back. All other descriptors get it clear.
- R4: The descriptor that receives a packet's last byte gets status bit 26 set. Only that descriptor also gets the five buffered application words written, at +16 through +32 and in arrival order.
- R5: Every used descriptor's status write-back has bit 31 set and holds in bits [22:0] the number of bytes written into its buffer. Bits 30:28 and 25:23 are zero. Each write-back is followed by a one-cycle `cmpl_o` pulse.
- R6: A sideband group (ended by `a_tlast`) with a word count other than five gives a one-cycle `sb_err_o` pulse. A group of exactly five gives none.
- R7: `s_tready` is high only while run is set and both idle and halted are clear.
- R8: After each completed descriptor, the current pointer takes that descriptor's next pointer. Idle is set when the completed descriptor's address equals the tail pointer.
- R9: A tail-pointer load clears idle. If a stream byte is waiting, the fetch of the current descriptor (a read request at the current pointer) is on the memory port in the second cycle after the load.
- R10: After reset, halted is 1, idle is 0, the current pointer is 0, and `s_tready` and `mem_req` are low. A rising edge of run clears halted and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run level; a rising edge restarts the engine |
| cur_ld_i | input | 1 | Load the current-descriptor pointer |
| cur_val_i | input | AW | Value for the current pointer |
| tail_ld_i | input | 1 | Load the tail pointer and clear idle |
| tail_val_i | input | AW | Value for the tail pointer |
| cur_o | output | AW | Current-descriptor pointer |
| idle_o | output | 1 | Chain finished at the tail |
| halted_o | output | 1 | Engine stopped (reset or already-complete descriptor) |
| cmpl_o | output | 1 | One-cycle pulse per descriptor write-back |
| sb_err_o | output | 1 | One-cycle pulse on a malformed sideband group |
| s_tvalid | input | 1 | Stream byte valid |
| s_tready | output | 1 | Stream byte accepted |
| s_tdata | input | 8 | Stream byte |
| s_tlast | input | 1 | Last byte of a packet |
| a_tvalid | input | 1 | Sideband word valid (always accepted) |
| a_tdata | input | 32 | Sideband word |
| a_tlast | input | 1 | Last word of a sideband group |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane write enables |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid while acknowledged |

## Verification
The assertions assume three things about the inputs:

- the sideband group for a packet arrives in full before that packet's last byte is written back;
- software does not load the current pointer while the engine walks the chain;
- no descriptor has a zero length.

The stimulus follows all three. Each sideband group is sent while the engine is idle, before its packet starts. Both pointers are loaded only during reset or idle periods. All chain lengths are nonzero. The memory acknowledge is stalled at pseudo-random points during one packet, so that fetch, byte and write-back steps each see waits.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 23;
  // descriptor word indices
  localparam int OFF_NEXT  = 0;
  localparam int OFF_BUF   = 1;
  localparam int OFF_LEN   = 2;
  localparam int OFF_STAT  = 3;
  localparam int OFF_APP   = 4;
  // status bit positions
  localparam int STAT_DONE = 31;
  localparam int STAT_SOF  = 27;
  localparam int STAT_EOF  = 26;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2,
    ST_WBACK = 2'd3
  } s2m_state_e;
endpackage

// File: rtl/s2m_app_buf.sv
module s2m_app_buf
  import s2m_pkg::*;
#(
  parameter int APP_WORDS = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               a_tvalid_i,
  input  logic [WORD_W-1:0]                  a_tdata_i,
  input  logic                               a_tlast_i,
  output logic [APP_WORDS-1:0][WORD_W-1:0]   app_o,
  output logic                               err_o
);
  localparam int CNT_W = $clog2(APP_WORDS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    err_d = 1'b0;
    if (a_tvalid_i) begin
      if (a_tlast_i) begin
        cnt_d = '0;
        err_d = (cnt_q != CNT_W'(APP_WORDS - 1));
      end else if (cnt_q != CNT_W'(APP_WORDS)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < APP_WORDS; g++) begin : g_word
    logic              wr_en;
    logic [WORD_W-1:0] word_q;
    assign wr_en = a_tvalid_i && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= a_tdata_i;
    end
    assign app_o[g] = word_q;
  end

  assign err_o = err_q;

  // R6: a short group must flag, an exact group must not
  p_short_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tvalid_i && a_tlast_i && cnt_q < CNT_W'(APP_WORDS - 1)) |=> err_o);
  p_exact_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_tvalid_i && a_tlast_i && cnt_q == CNT_W'(APP_WORDS - 1)) |=> !err_o);
endmodule

// File: rtl/s2m_chain_ctl.sv
module s2m_chain_ctl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cur_ld_i,
  input  logic [AW-1:0] cur_val_i,
  input  logic          tail_ld_i,
  input  logic [AW-1:0] tail_val_i,
  input  logic          adv_i,
  input  logic [AW-1:0] nxt_i,
  input  logic          halt_set_i,
  output logic [AW-1:0] cur_o,
  output logic          idle_o,
  output logic          halted_o,
  output logic          intake_en_o
);
  logic [AW-1:0] cur_q, cur_d, tail_q;
  logic          idle_q, idle_d, halted_q, halted_d, run_q;
  logic          run_rise;

  assign run_rise = run_i && !run_q;

  always_comb begin
    cur_d = cur_q;
    if (cur_ld_i)   cur_d = cur_val_i;
    else if (adv_i) cur_d = nxt_i;

    idle_d = idle_q;
    if (tail_ld_i || run_rise)         idle_d = 1'b0;
    else if (adv_i && cur_q == tail_q) idle_d = 1'b1;

    halted_d = halted_q;
    if (run_rise)        halted_d = 1'b0;
    else if (halt_set_i) halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      tail_q   <= '0;
      idle_q   <= 1'b0;
      halted_q <= 1'b1;
      run_q    <= 1'b0;
    end else begin
      cur_q    <= cur_d;
      if (tail_ld_i) tail_q <= tail_val_i;
      idle_q   <= idle_d;
      halted_q <= halted_d;
      run_q    <= run_i;
    end
  end

  assign cur_o       = cur_q;
  assign idle_o      = idle_q;
  assign halted_o    = halted_q;
  assign intake_en_o = run_i && !idle_q && !halted_q;

  // R8: finishing the tail descriptor parks the engine
  p_idle_on_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && cur_q == tail_q && !tail_ld_i && !run_rise) |=> idle_o);
  // R8: the chain walks through next pointers
  p_adv_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !cur_ld_i) |=> (cur_o == $past(nxt_i)));
  // R2: a fault from the sequencer stops the engine
  p_fault_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_set_i && !run_rise) |=> halted_o);
endmodule

// File: rtl/s2m_sg_fsm.sv
module s2m_sg_fsm
  import s2m_pkg::*;
#(
  parameter int AW        = 32,
  parameter int APP_WORDS = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              intake_en_i,
  input  logic [AW-1:0]                     cur_i,
  output logic                              adv_o,
  output logic [AW-1:0]                     nxt_o,
  output logic                              halt_set_o,
  output logic                              cmpl_o,
  input  logic [APP_WORDS-1:0][WORD_W-1:0]  app_i,
  input  logic                              s_tvalid_i,
  input  logic [7:0]                        s_tdata_i,
  input  logic                              s_tlast_i,
  output logic                              s_tready_o,
  output logic                              mem_req_o,
  output logic                              mem_we_o,
  output logic [AW-1:0]                     mem_addr_o,
  output logic [WORD_W-1:0]                 mem_wdata_o,
  output logic [3:0]                        mem_wstrb_o,
  input  logic                              mem_ack_i,
  input  logic [WORD_W-1:0]                 mem_rdata_i
);
  localparam int IDX_W = (APP_WORDS + 1 > 4) ? $clog2(APP_WORDS + 1) : 2;

  s2m_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, app_idx;
  logic [AW-1:0]    nxt_q, nxt_d, bptr_q, bptr_d;
  logic [LEN_W-1:0] rem_q, rem_d, cnt_q, cnt_d;
  logic             sof_q, sof_d, eof_q, eof_d, cmpl_q, done;
  logic             hs;
  logic [WORD_W-1:0] stat_word;

  assign app_idx = (idx_q == '0) ? '0 : idx_q - 1'b1;

  always_comb begin
    stat_word            = '0;
    stat_word[STAT_DONE] = 1'b1;
    stat_word[STAT_SOF]  = sof_q;
    stat_word[STAT_EOF]  = eof_q;
    stat_word[LEN_W-1:0] = cnt_q;
  end

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  nxt_d = nxt_q;  bptr_d = bptr_q;
    rem_d = rem_q; cnt_d = cnt_q; sof_d = sof_q; eof_d = eof_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0;
    mem_wdata_o = '0; mem_wstrb_o = '0; s_tready_o = 1'b0;
    adv_o = 1'b0; halt_set_o = 1'b0; done = 1'b0; hs = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (intake_en_i && s_tvalid_i) begin
          st_d  = ST_FETCH;
          idx_d = '0;
        end
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_i + AW'({idx_q, 2'b00});
        if (mem_ack_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(OFF_NEXT)) nxt_d = mem_rdata_i[AW-1:0];
          if (idx_q == IDX_W'(OFF_BUF))  bptr_d = mem_rdata_i[AW-1:0];
          if (idx_q == IDX_W'(OFF_LEN))  rem_d = mem_rdata_i[LEN_W-1:0];
          if (idx_q == IDX_W'(OFF_STAT)) begin
            idx_d = '0;
            cnt_d = '0;
            eof_d = 1'b0;
            if (mem_rdata_i[STAT_DONE]) begin
              halt_set_o = 1'b1;
              st_d       = ST_WAIT;
            end else begin
              st_d = (rem_q == '0) ? ST_WBACK : ST_MOVE;
            end
          end
        end
      end
      ST_MOVE: begin
        s_tready_o  = intake_en_i && mem_ack_i;
        mem_req_o   = s_tvalid_i && intake_en_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = bptr_q;
        mem_wdata_o = {4{s_tdata_i}};
        mem_wstrb_o = 4'b0001 << bptr_q[1:0];
        hs          = s_tvalid_i && s_tready_o;
        if (hs) begin
          bptr_d = bptr_q + 1'b1;
          cnt_d  = cnt_q + 1'b1;
          rem_d  = rem_q - 1'b1;
          if (s_tlast_i || rem_q == LEN_W'(1)) begin
            eof_d = s_tlast_i;
            st_d  = ST_WBACK;
            idx_d = '0;
          end
        end
      end
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wstrb_o = 4'hF;
        if (idx_q == '0) begin
          mem_addr_o  = cur_i + AW'(OFF_STAT * 4);
          mem_wdata_o = stat_word;
        end else begin
          mem_addr_o  = cur_i + AW'((OFF_APP + int'(app_idx)) * 4);
          mem_wdata_o = app_i[app_idx];
        end
        if (mem_ack_i) begin
          if ((idx_q == '0 && !eof_q) || idx_q == IDX_W'(APP_WORDS)) begin
            done  = 1'b1;
            adv_o = 1'b1;
            sof_d = eof_q;
            st_d  = ST_WAIT;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT; idx_q <= '0; nxt_q <= '0; bptr_q <= '0;
      rem_q <= '0; cnt_q <= '0; sof_q <= 1'b1; eof_q <= 1'b0; cmpl_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; nxt_q <= nxt_d; bptr_q <= bptr_d;
      rem_q <= rem_d; cnt_q <= cnt_d; sof_q <= sof_d; eof_q <= eof_d;
      cmpl_q <= done;
    end
  end

  assign nxt_o  = nxt_q;
  assign cmpl_o = cmpl_q;

  // R5: write-backs are separated by at least a fetch, so pulses never merge
  p_cmpl_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_o |=> !cmpl_o);
  // R1: the byte phase is only entered with buffer room left
  p_move_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MOVE) |-> (rem_q != '0));
  // R1: a byte store hits exactly one lane
  p_byte_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && st_q == ST_MOVE) |-> ($countones(mem_wstrb_o) == 1));
endmodule

// File: rtl/s2m_sg_engine.sv
module s2m_sg_engine
  import s2m_pkg::*;
#(
  parameter int AW        = 32,
  parameter int APP_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              cur_ld_i,
  input  logic [AW-1:0]     cur_val_i,
  input  logic              tail_ld_i,
  input  logic [AW-1:0]     tail_val_i,
  output logic [AW-1:0]     cur_o,
  output logic              idle_o,
  output logic              halted_o,
  output logic              cmpl_o,
  output logic              sb_err_o,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [7:0]        s_tdata,
  input  logic              s_tlast,
  input  logic              a_tvalid,
  input  logic [31:0]       a_tdata,
  input  logic              a_tlast,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  logic                             intake_en, adv, halt_set;
  logic [AW-1:0]                    nxt;
  logic [APP_WORDS-1:0][WORD_W-1:0] app;

  s2m_app_buf #(.APP_WORDS(APP_WORDS)) u_app (
    .clk(clk), .rst_n(rst_n),
    .a_tvalid_i(a_tvalid), .a_tdata_i(a_tdata), .a_tlast_i(a_tlast),
    .app_o(app), .err_o(sb_err_o)
  );

  s2m_chain_ctl #(.AW(AW)) u_chain (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cur_ld_i(cur_ld_i), .cur_val_i(cur_val_i),
    .tail_ld_i(tail_ld_i), .tail_val_i(tail_val_i),
    .adv_i(adv), .nxt_i(nxt), .halt_set_i(halt_set),
    .cur_o(cur_o), .idle_o(idle_o), .halted_o(halted_o),
    .intake_en_o(intake_en)
  );

  s2m_sg_fsm #(.AW(AW), .APP_WORDS(APP_WORDS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .intake_en_i(intake_en), .cur_i(cur_o),
    .adv_o(adv), .nxt_o(nxt), .halt_set_o(halt_set), .cmpl_o(cmpl_o),
    .app_i(app),
    .s_tvalid_i(s_tvalid), .s_tdata_i(s_tdata), .s_tlast_i(s_tlast),
    .s_tready_o(s_tready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wstrb_o(mem_wstrb),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // R7: intake only while running, not idle and not halted
  p_tready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> (run_i && !idle_o && !halted_o));
endmodule

// File: tb/s2m_sg_engine_test.sv
module s2m_sg_engine_test;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, run_i, cur_ld_i, tail_ld_i;
  logic [31:0] cur_val_i, tail_val_i, cur_o;
  logic        idle_o, halted_o, cmpl_o, sb_err_o;
  logic        s_tvalid, s_tready, s_tlast;
  logic [7:0]  s_tdata;
  logic        a_tvalid, a_tlast;
  logic [31:0] a_tdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  s2m_sg_engine uut (.*);

  // memory model with a backdoor port used during reset
  logic [31:0] mem [0:255];
  logic        bd_we;
  logic [7:0]  bd_addr;
  logic [31:0] bd_data;
  logic        stall = 1'b0, stall_en;
  logic [7:0]  lfsr = 8'h5A;

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ack   = !stall;

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    else if (mem_req && mem_we && mem_ack)
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(negedge clk) begin
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    stall <= stall_en && lfsr[0];
  end

  int tests = 0, fails = 0, n_cmpl = 0, n_err = 0;
  logic [63:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  // monitor: descriptor-region writes are popped and compared (R3 R4 R5)
  always begin
    @(negedge clk);
    #2;
    if (rst_n && mem_req && mem_we && mem_ack && mem_addr >= 32'h200) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected descriptor write", {mem_addr, mem_wdata}, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3/R4/R5 write-back", {mem_addr, mem_wdata}, e);
      end
    end
    if (rst_n && cmpl_o)   n_cmpl++;
    if (rst_n && sb_err_o) n_err++;
  end

  function automatic logic [31:0] init_word(input int i);
    int d, w;
    if (i < 'h80) return 32'hEEEE_EEEE;
    d = (i - 'h80) >> 4;
    w = (i - 'h80) & 15;
    if (d >= 4) return 32'h0;
    case (w)
      0: return 32'h200 + ((d + 1) % 4) * 32'h40;
      1: return d * 32'h40;
      2: case (d) 0: return 6; 1: return 4; 2: return 10; default: return 8; endcase
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic send_app(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      a_tvalid = 1'b1; a_tdata = base + i; a_tlast = (i == n - 1);
      @(negedge clk);
    end
    a_tvalid = 1'b0; a_tlast = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      logic got;
      s_tvalid = 1'b1; s_tdata = base + 8'(i); s_tlast = (i == n - 1);
      got = 1'b0;
      while (!got) begin
        #2;
        got = s_tready;
        @(negedge clk);
      end
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic chk_buf(input int base, input int n, input logic [7:0] first, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rd_byte(base + i) != first + 8'(i)) bad++;
    chk(bad == 0, req, 64'(bad), 64'h0);
    chk(rd_byte(base + n) == 8'hEE, {req, " boundary"}, 64'(rd_byte(base + n)), 64'hEE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_i = 1'b0; cur_ld_i = 1'b0; tail_ld_i = 1'b0;
    cur_val_i = '0; tail_val_i = '0; s_tvalid = 1'b0; s_tdata = '0; s_tlast = 1'b0;
    a_tvalid = 1'b0; a_tdata = '0; a_tlast = 1'b0; stall_en = 1'b0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      bd_we = 1'b1; bd_addr = 8'(i); bd_data = init_word(i);
    end
    @(negedge clk);
    bd_we = 1'b0;
    #2;
    // R10 reset state
    chk(halted_o == 1'b1, "R10 halted", 64'(halted_o), 64'h1);
    chk(idle_o == 1'b0, "R10 idle", 64'(idle_o), 64'h0);
    chk(cur_o == 32'h0, "R10 cur", 64'(cur_o), 64'h0);
    chk(s_tready == 1'b0 && mem_req == 1'b0, "R10 quiet ports", {s_tready, mem_req}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: no intake while stopped
    s_tvalid = 1'b1;
    @(negedge clk); #2;
    chk(s_tready == 1'b0, "R7 tready while not running", 64'(s_tready), 64'h0);
    @(negedge clk);
    s_tvalid = 1'b0;
    cur_ld_i = 1'b1; cur_val_i = 32'h200; tail_ld_i = 1'b1; tail_val_i = 32'h240;
    @(negedge clk);
    cur_ld_i = 1'b0; tail_ld_i = 1'b0; run_i = 1'b1;
    @(negedge clk);

    // packet 1: 9 bytes over D0 (6) and D1 (3)
    expect_wr(32'h20C, 32'h8800_0006);
    expect_wr(32'h24C, 32'h8400_0003);
    for (int k = 0; k < 5; k++) expect_wr(32'h250 + 4*k, 32'hA000_0000 + k);
    send_app(5, 32'hA000_0000);
    send_pkt(9, 8'h10);
    while (!idle_o) @(negedge clk);
    #2;
    chk(cur_o == 32'h280, "R8 pointer advanced", 64'(cur_o), 64'h280);
    chk(idle_o == 1'b1, "R8 idle at tail", 64'(idle_o), 64'h1);
    @(negedge clk);
    s_tvalid = 1'b1;
    @(negedge clk); #2;
    chk(s_tready == 1'b0, "R7 tready while idle", 64'(s_tready), 64'h0);
    @(negedge clk);
    s_tvalid = 1'b0;

    // R6: short sideband group then an exact one
    send_app(3, 32'hC000_0000);
    repeat (2) @(negedge clk);
    chk(n_err == 1, "R6 short group flagged", 64'(n_err), 64'h1);
    send_app(5, 32'hB000_0000);
    repeat (2) @(negedge clk);
    chk(n_err == 1, "R6 exact group clean", 64'(n_err), 64'h1);

    // packet 2: 12 bytes over D2 (10) and D3 (2), with memory stalls
    expect_wr(32'h28C, 32'h8800_000A);
    expect_wr(32'h2CC, 32'h8400_0002);
    for (int k = 0; k < 5; k++) expect_wr(32'h2D0 + 4*k, 32'hB000_0000 + k);
    stall_en = 1'b1;
    @(negedge clk);
    fork
      send_pkt(12, 8'h40);
    join_none
    tail_ld_i = 1'b1; tail_val_i = 32'h2C0;
    @(negedge clk);
    tail_ld_i = 1'b0;
    @(negedge clk); #2;
    chk(mem_req && !mem_we && mem_addr == 32'h280, "R9 fetch after tail load",
        {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 32'h280});
    while (!idle_o) @(negedge clk);
    stall_en = 1'b0;
    #2;
    chk(cur_o == 32'h200, "R8 chain wraps", 64'(cur_o), 64'h200);

    // R2: D0 already complete -> halted, nothing accepted
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 8'h99; s_tlast = 1'b0;
    tail_ld_i = 1'b1; tail_val_i = 32'h240;
    @(negedge clk);
    tail_ld_i = 1'b0;
    repeat (12) @(negedge clk);
    #2;
    chk(halted_o == 1'b1, "R2 halted on complete descriptor", 64'(halted_o), 64'h1);
    chk(s_tready == 1'b0 && mem_req == 1'b0, "R2 no intake after fault", {s_tready, mem_req}, 64'h0);
    @(negedge clk);
    s_tvalid = 1'b0;

    // R1 buffer contents and boundaries
    chk_buf('h000, 6, 8'h10, "R1 D0 bytes");
    chk_buf('h040, 3, 8'h16, "R1 D1 bytes");
    chk_buf('h080, 10, 8'h40, "R1 D2 bytes");
    chk_buf('h0C0, 2, 8'h4A, "R1 D3 bytes");
    chk(n_cmpl == 4, "R5 completion pulses", 64'(n_cmpl), 64'h4);
    chk(exp_q.size() == 0, "R4 all write-backs seen", 64'(exp_q.size()), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule